// File: doc/BRIEF.md
# Inrush Start-Up Timer Supervisor

This block sequences the power-on of one port. A turn-on request enables the external gate ramp and starts a start-up window. The window is measured in pulses of a periodic tick input. While the window runs, the block watches a synchronous comparator flag that shows whether the port current is still being held at the inrush limit. The port is judged once, on the tick that closes the window. If the current has left the limit by then, the port is declared fully on. If it is still limited, the gate is dropped and a sticky start fault is raised. An earlier limit event, or a drop out of the limit, does not end the window early.

A gate-boost output lets the analog driver enhance the MOSFET fully. It is high once the current falls below the inrush limit during the window, and it stays high in the on state. A turn-off request aborts the sequence from any phase without a fault. The start fault blocks new turn-on requests until a clear pulse removes it. The block carries no data stream, so every pin is a plain control or status level sampled on the rising clock edge.

Top module: `inrush_start_supervisor`

## Requirements
- R1: After reset, gate_en, port_on, gate_boost and start_fault are all 0.
- R2: A turn_on pulse with no fault, while idle and with turn_off low, sets gate_en to 1 on the next clock edge. The window count starts at zero, and a tick in that same cycle is not counted.
- R3: The window closes on the START_TICKS-th cycle in which tick is 1 while ramping. Cycles without a tick do not count, and port_on stays 0 until that tick, whatever at_limit does.
- R4: If at_limit is 0 on the closing tick, port_on becomes 1 on that clock edge and gate_en stays 1.
- R5: If at_limit is 1 on the closing tick, gate_en returns to 0 and start_fault becomes 1 on that clock edge.
- R6: gate_boost is 1 while ramping with at_limit at 0, 0 while ramping with at_limit at 1, 1 in the on state, and 0 when idle.
- R7: turn_off at any time returns the block to idle (gate_en and port_on at 0) on the next edge without setting start_fault. This holds even in the cycle of the closing tick.
- R8: start_fault stays 1 until a fault_clr pulse. If a fault is raised in the same cycle as a clear, the raise wins.
- R9: turn_on has no effect while start_fault is 1, including the cycle in which fault_clr is applied.
- R10: turn_on while ramping or on has no effect: the window is not restarted and the on state is kept.
- R11: at_limit at 1 before the closing tick, or in the on state, raises no fault and does not change the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| turn_on | input | 1 | Request to power the port |
| turn_off | input | 1 | Request to remove power; overrides everything else |
| tick | input | 1 | Time-base pulse, one per window unit |
| at_limit | input | 1 | Current is held at the inrush limit (synchronous) |
| fault_clr | input | 1 | Clears the sticky start fault |
| gate_en | output | 1 | Enables the external gate ramp |
| gate_boost | output | 1 | Allows full gate enhancement |
| port_on | output | 1 | Port declared fully powered |
| start_fault | output | 1 | Sticky start-up fault |

## Verification
The assertions assume that every input is synchronous to clk and settled before the rising edge. They also assume that tick is a level that is sampled once per cycle, so a tick held high counts once per cycle. They assume nothing about pulse widths or mutual exclusion: turn_on, turn_off, tick and fault_clr may coincide in any mix, and the properties state the priority that results. The stimulus changes inputs a short time after each rising edge and samples outputs at the same point. It also deliberately overlaps turn_off with the closing tick, and fault_clr with both a new fault and a turn_on.

// File: rtl/inrush_pkg.sv
package inrush_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RAMP = 2'd1,
    PH_ON   = 2'd2
  } phase_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/inrush_window_timer.sv
module inrush_window_timer #(
  parameter int unsigned START_TICKS = 50,
  localparam int unsigned CW = inrush_pkg::cnt_width(START_TICKS),
  localparam logic [CW-1:0] LAST = CW'(START_TICKS - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  output logic          expire,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == LAST);
  assign count  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick && !expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));

  p_count_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/inrush_phase_fsm.sv
module inrush_phase_fsm
  import inrush_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   turn_on,
  input  logic   turn_off,
  input  logic   at_limit,
  input  logic   fault_held,
  input  logic   expire,
  output phase_t phase,
  output logic   start_fail
);

  phase_t ph_q, ph_d;

  always_comb begin
    ph_d       = ph_q;
    start_fail = 1'b0;
    if (turn_off) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (turn_on && !fault_held) ph_d = PH_RAMP;
        PH_RAMP: begin
          if (expire) begin
            if (at_limit) begin
              ph_d       = PH_IDLE;
              start_fail = 1'b1;
            end else begin
              ph_d = PH_ON;
            end
          end
        end
        PH_ON:   ph_d = PH_ON;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;

  p_off_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    turn_off |=> (ph_q == PH_IDLE));

  p_blocked_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && fault_held) |=> (ph_q == PH_IDLE));

  p_on_only_after_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RAMP && !expire) |=> (ph_q != PH_ON));

  p_fail_needs_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_fail |-> (expire && at_limit));

endmodule

// File: rtl/inrush_fault_latch.sv
module inrush_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic fault_o
);

  logic f_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     f_q <= 1'b0;
    else if (set_i) f_q <= 1'b1;
    else if (clr_i) f_q <= 1'b0;
  end

  assign fault_o = f_q;

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (f_q && !clr_i) |=> f_q);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> f_q);

endmodule

// File: rtl/inrush_start_supervisor.sv
module inrush_start_supervisor
  import inrush_pkg::*;
#(
  parameter int unsigned START_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic turn_on,
  input  logic turn_off,
  input  logic tick,
  input  logic at_limit,
  input  logic fault_clr,
  output logic gate_en,
  output logic gate_boost,
  output logic port_on,
  output logic start_fault
);

  localparam int unsigned CW = cnt_width(START_TICKS);

  phase_t        phase;
  logic          expire;
  logic          start_fail;
  logic          fault_q;
  logic [CW-1:0] win_cnt;

  inrush_window_timer #(.START_TICKS(START_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (phase == PH_RAMP),
    .tick   (tick),
    .expire (expire),
    .count  (win_cnt)
  );

  inrush_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .turn_on    (turn_on),
    .turn_off   (turn_off),
    .at_limit   (at_limit),
    .fault_held (fault_q),
    .expire     (expire),
    .phase      (phase),
    .start_fail (start_fail)
  );

  inrush_fault_latch u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (start_fail),
    .clr_i   (fault_clr),
    .fault_o (fault_q)
  );

  assign gate_en     = (phase != PH_IDLE);
  assign port_on     = (phase == PH_ON);
  assign gate_boost  = (phase == PH_ON) || ((phase == PH_RAMP) && !at_limit);
  assign start_fault = fault_q;

  p_on_implies_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    port_on |-> gate_en);

  p_boost_implies_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_boost |-> gate_en);

  p_fault_drops_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_fault) |-> !gate_en);

  p_on_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (port_on && !turn_off) |=> port_on);

  p_ramp_idle_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> (win_cnt == '0));

endmodule

// File: tb/inrush_start_supervisor_test.sv
module inrush_start_supervisor_test;

  localparam int unsigned N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic turn_on = 0, turn_off = 0, tick = 0, at_limit = 0, fault_clr = 0;
  logic gate_en, gate_boost, port_on, start_fault;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  inrush_start_supervisor #(.START_TICKS(N)) uut (
    .clk(clk), .rst_n(rst_n), .turn_on(turn_on), .turn_off(turn_off),
    .tick(tick), .at_limit(at_limit), .fault_clr(fault_clr),
    .gate_en(gate_en), .gate_boost(gate_boost), .port_on(port_on),
    .start_fault(start_fault)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one clock: apply inputs, pass the edge, sample 2 ns after it
  task automatic cyc(input logic on, input logic off, input logic tk, input logic clr);
    turn_on = on; turn_off = off; tick = tk; fault_clr = clr;
    @(posedge clk); #2;
    turn_on = 0; turn_off = 0; tick = 0; fault_clr = 0;
  endtask

  task automatic go_idle();
    cyc(0, 1, 0, 1);
    cyc(0, 0, 0, 0);
  endtask

  // full start-up: limit released after 'drop' ticks, final limit value 'lim_end'
  task automatic startup(input int drop, input logic lim_end);
    at_limit = 1'b1;
    cyc(1, 0, 1, 0);  // tick in start cycle is not counted (R2)
    chk("R2", "gate_en after turn_on", gate_en, 1'b1);
    for (int i = 0; i < int'(N); i++) begin
      at_limit = (i >= drop) ? 1'b0 : 1'b1;
      if (i == int'(N) - 1) at_limit = lim_end;
      #1;
      chk("R6", "gate_boost ramping", gate_boost, !at_limit);
      for (int g = 0; g < (i % 3); g++) begin
        cyc(0, 0, 0, 0);
        chk("R3", "no tick keeps ramp", port_on, 1'b0);
      end
      cyc(0, 0, 1, 0);
      if (i < int'(N) - 1) begin
        chk("R3", "port_on before window end", port_on, 1'b0);
        chk("R11", "no fault during window", start_fault, 1'b0);
      end
    end
    if (lim_end) begin
      chk("R5", "gate_en after failed start", gate_en, 1'b0);
      chk("R5", "start_fault set", start_fault, 1'b1);
    end else begin
      chk("R4", "port_on after window", port_on, 1'b1);
      chk("R4", "gate_en stays", gate_en, 1'b1);
      chk("R6", "gate_boost when on", gate_boost, 1'b1);
    end
    at_limit = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "gate_en reset", gate_en, 1'b0);
    chk("R1", "port_on reset", port_on, 1'b0);
    chk("R1", "gate_boost reset", gate_boost, 1'b0);
    chk("R1", "start_fault reset", start_fault, 1'b0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);

    // sweep: release point x final limit level
    for (int lim = 0; lim < 2; lim++) begin
      for (int drop = 0; drop <= int'(N); drop++) begin
        startup(drop, lim[0]);
        go_idle();
        chk("R8", "fault cleared", start_fault, 1'b0);
      end
    end

    // R11: limit while on changes nothing
    startup(0, 1'b0);
    at_limit = 1'b1;
    repeat (3) cyc(0, 0, 1, 0);
    chk("R11", "on kept under limit", port_on, 1'b1);
    chk("R11", "no fault when on", start_fault, 1'b0);
    chk("R6", "boost on under limit", gate_boost, 1'b1);
    at_limit = 1'b0;
    // R10: turn_on while on
    cyc(1, 0, 1, 0);
    chk("R10", "on kept after turn_on", port_on, 1'b1);
    cyc(0, 1, 0, 0);
    chk("R7", "off from on", gate_en, 1'b0);

    // R7 sweep: abort after k ticks, last one overlaps the closing tick
    for (int k = 0; k < int'(N); k++) begin
      at_limit = 1'b1;
      cyc(1, 0, 0, 0);
      for (int i = 0; i < k; i++) cyc(0, 0, 1, 0);
      cyc(0, 1, 1, 0);
      chk("R7", "abort gate_en", gate_en, 1'b0);
      chk("R7", "abort no fault", start_fault, 1'b0);
      chk("R7", "abort port_on", port_on, 1'b0);
      at_limit = 1'b0;
      cyc(0, 0, 1, 0);
    end

    // R10: turn_on in mid window does not restart the count
    at_limit = 1'b0;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(1, 0, 1, 0);
    for (int i = 3; i < int'(N); i++) cyc(0, 0, 1, 0);
    chk("R10", "window not restarted", port_on, 1'b1);
    go_idle();

    // R8/R9: fault hold, blocked start, clear with turn_on
    startup(N, 1'b1);
    repeat (2) cyc(0, 0, 1, 0);
    chk("R8", "fault sticky", start_fault, 1'b1);
    cyc(1, 0, 0, 0);
    chk("R9", "turn_on blocked by fault", gate_en, 1'b0);
    cyc(1, 0, 0, 1);
    chk("R9", "turn_on with clear blocked", gate_en, 1'b0);
    chk("R8", "clear works", start_fault, 1'b0);
    cyc(1, 0, 0, 0);
    chk("R2", "start after clear", gate_en, 1'b1);
    // R8: raise and clear in same cycle, raise wins
    at_limit = 1'b1;
    for (int i = 0; i < int'(N) - 1; i++) cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 1);
    chk("R8", "set wins over clear", start_fault, 1'b1);
    chk("R5", "gate off on fault", gate_en, 1'b0);
    at_limit = 1'b0;
    go_idle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule